// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps an SDRAM's contents alive on behalf of a memory controller. An interval timer, derived from the clock frequency, the retention period and the number of rows, posts one owed refresh per interval. A saturating counter keeps the owed refreshes while the command sequencer is busy, and an urgent flag rises once enough have piled up. The manager asks for a command slot with `ref_req`. The sequencer answers with `ref_gnt` in the cycle it places an auto-refresh on the bus. After each refresh, a lock-out window of `T_RC` cycles keeps every other command off the bus.

The block also drives the clock-enable pin. A self-refresh request taken in normal operation drops `cke` and clears the owed count. Requests to leave are ignored until `cke` has been low for the minimum self-refresh time. On exit, `cke` rises and the sequencer must issue NOPs for a window of `max(EXIT_NOP, T_RC)` cycles. The manager then demands one auto-refresh per row, back to back, because the row the device refreshed last is unknown. After that it returns to normal interval scheduling.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: Outside self-refresh, one refresh is added to `owed` every `INTERVAL = (CLK_KHZ*PERIOD_MS)/ROWS` cycles, counted from reset release or from the last self-refresh exit.
- R2: In normal operation `ref_req` is high exactly when `owed` is non-zero and `lockout` is low. A cycle with `ref_gnt` and `ref_req` both high lowers `owed` by one.
- R3: `ref_gnt` while `ref_req` is low has no effect on `owed` or `lockout`.
- R4: `owed` saturates at `DEFICIT_MAX`. `ref_urgent` is high whenever `owed >= URGENT_AT`.
- R5: After an accepted grant, `lockout` is high for exactly `T_RC` cycles, and `ref_req` stays low during that time.
- R6: `sr_enter_req` in normal operation with `lockout` low drives `cke` low from the next cycle, raises `sr_active` and clears `owed`. While `cke` is low, `ref_req` stays low.
- R7: `sr_exit_req` is honoured only after `cke` has been low for `T_RAS+1` cycles. `cke` then rises on the next cycle and `sr_active` falls.
- R8: From the cycle `cke` rises, `lockout` is high and `ref_req` low for `max(EXIT_NOP, T_RC)` cycles.
- R9: After self-refresh exit the block requests `ROWS` auto-refreshes. These grants leave `owed` untouched, the interval timer restarts at exit, and after the `ROWS`-th grant, grants again lower `owed`.
- R10: `sr_enter_req` during the post-exit refresh burst is ignored, and `cke` stays high.
- R11: During and right after reset, `cke` is 1 and `ref_req`, `lockout`, `sr_active`, `ref_urgent` and `owed` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_enter_req | input | 1 | Ask to enter self-refresh |
| sr_exit_req | input | 1 | Ask to leave self-refresh (held until honoured) |
| ref_gnt | input | 1 | Sequencer issues an auto-refresh this cycle |
| ref_req | output | 1 | Auto-refresh slot wanted |
| ref_urgent | output | 1 | Owed count has reached the urgency threshold |
| owed | output | clog2(DEFICIT_MAX+1) | Postponed refreshes |
| lockout | output | 1 | No command other than NOP may issue |
| cke | output | 1 | Clock-enable drive to the device |
| sr_active | output | 1 | Device is in self-refresh |

## Verification
The bench builds the block with `CLK_KHZ=256`, `PERIOD_MS=1` and `ROWS=16`, which gives a 16-cycle refresh interval and a 16-refresh burst after exit. Counter saturation at `DEFICIT_MAX=6` and the urgent threshold at 3 can therefore be reached within a couple of hundred cycles. `T_RC=4` and `T_RAS=6` are short enough to land lock-out ends and the earliest legal exit on known cycles. They also leave `T_RC` as the larger term of the exit window. A mid-burst probe of `owed` tells a timer restarted at exit apart from one that kept running.

// File: rtl/sdr_ref_pkg.sv
package sdr_ref_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SELF  = 2'd1,
    ST_BURST = 2'd2
  } mgr_state_t;

  // cycles between two owed refreshes
  function automatic int refresh_interval(input int clk_khz, input int period_ms,
                                          input int rows);
    return (clk_khz * period_ms) / rows;
  endfunction

  // NOP window after clock-enable returns high
  function automatic int exit_window(input int nop_cycles, input int trc_cycles);
    return (nop_cycles > trc_cycles) ? nop_cycles : trc_cycles;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign tick = run && !clear && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) cnt <= '0;
    else if (run) cnt <= (cnt == LAST) ? '0 : cnt + CW'(1);
  end

  // R1: two ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ref_deficit_ctr.sv
module ref_deficit_ctr #(
  parameter int MAX_OWED  = 8,
  parameter int URGENT_AT = 4,
  localparam int W = $clog2(MAX_OWED + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] count,
  output logic         urgent
);
  localparam logic [W-1:0] TOP = W'(MAX_OWED);
  localparam logic [W-1:0] THR = W'(URGENT_AT);

  assign urgent = (count >= THR);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) count <= '0;
    else if (inc && !dec && count != TOP) count <= count + W'(1);
    else if (dec && !inc && count != '0) count <= count - W'(1);
  end

  assert_tick_adds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && !clear && count != TOP) |=> count == $past(count) + W'(1));

  assert_grant_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !clear && count != '0) |=> count == $past(count) - W'(1));

  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == TOP && !dec && !clear) |=> count == TOP);

endmodule

// File: rtl/ref_lockout_timer.sv
module ref_lockout_timer #(
  parameter int MAXV = 4,
  localparam int W = $clog2(MAXV + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt;

  assign busy = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (load) cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end

  // R5 / R8: a load always opens a window
  assert_load_opens_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);

  assert_window_counts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> cnt == $past(cnt) - W'(1));

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
  import sdr_ref_pkg::*;
#(
  parameter int CLK_KHZ     = 100000,
  parameter int PERIOD_MS   = 64,
  parameter int ROWS        = 4096,
  parameter int T_RC        = 7,
  parameter int T_RAS       = 5,
  parameter int EXIT_NOP    = 2,
  parameter int DEFICIT_MAX = 8,
  parameter int URGENT_AT   = 4
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sr_enter_req,
  input  logic                               sr_exit_req,
  input  logic                               ref_gnt,
  output logic                               ref_req,
  output logic                               ref_urgent,
  output logic [$clog2(DEFICIT_MAX+1)-1:0]   owed,
  output logic                               lockout,
  output logic                               cke,
  output logic                               sr_active
);
  localparam int INTERVAL = refresh_interval(CLK_KHZ, PERIOD_MS, ROWS);
  localparam int EXIT_WIN = exit_window(EXIT_NOP, T_RC);
  localparam int LK_W     = $clog2(EXIT_WIN + 1);
  localparam int SR_W     = $clog2(T_RAS + 1);
  localparam int BL_W     = $clog2(ROWS + 1);
  localparam logic [SR_W-1:0] SR_MIN = SR_W'(T_RAS);

  mgr_state_t      state;
  logic            cke_q;
  logic [SR_W-1:0] sr_cnt;
  logic [BL_W-1:0] burst_left;

  // named internal events
  logic tick, accepted, run_take, burst_take, enter_fire, exit_fire;
  logic [LK_W-1:0] lk_val;

  assign accepted   = ref_gnt && ref_req;
  assign run_take   = accepted && (state == ST_RUN);
  assign burst_take = accepted && (state == ST_BURST);
  assign enter_fire = (state == ST_RUN) && sr_enter_req && !lockout;
  assign exit_fire  = (state == ST_SELF) && sr_exit_req && (sr_cnt == SR_MIN);
  assign lk_val     = exit_fire ? LK_W'(EXIT_WIN) : LK_W'(T_RC);

  assign ref_req = !lockout &&
                   (((state == ST_RUN) && (owed != '0)) ||
                    ((state == ST_BURST) && (burst_left != '0)));
  assign cke       = cke_q;
  assign sr_active = (state == ST_SELF);

  ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (state != ST_SELF),
    .clear (enter_fire || exit_fire),
    .tick  (tick)
  );

  ref_deficit_ctr #(.MAX_OWED(DEFICIT_MAX), .URGENT_AT(URGENT_AT)) u_deficit (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (enter_fire),
    .inc    (tick),
    .dec    (run_take),
    .count  (owed),
    .urgent (ref_urgent)
  );

  ref_lockout_timer #(.MAXV(EXIT_WIN)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accepted || exit_fire),
    .load_val (lk_val),
    .busy     (lockout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_RUN;
      cke_q      <= 1'b1;
      sr_cnt     <= '0;
      burst_left <= '0;
    end else begin
      unique case (state)
        ST_RUN: if (enter_fire) begin
          state  <= ST_SELF;
          cke_q  <= 1'b0;
          sr_cnt <= '0;
        end
        ST_SELF: begin
          if (sr_cnt != SR_MIN) sr_cnt <= sr_cnt + SR_W'(1);
          if (exit_fire) begin
            state      <= ST_BURST;
            cke_q      <= 1'b1;
            burst_left <= BL_W'(ROWS);
          end
        end
        ST_BURST: if (burst_take) begin
          burst_left <= burst_left - BL_W'(1);
          if (burst_left == BL_W'(1)) state <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assert_grant_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accepted |=> (lockout && !ref_req));

  assert_no_req_self_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !ref_req);

  assert_entry_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (owed == '0));

  assert_min_self_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> ($past(sr_cnt) == SR_MIN));

  assert_exit_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (lockout && !ref_req));

endmodule

// File: tb/sim_sdram_refresh_mgr.sv
module sim_sdram_refresh_mgr;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sr_enter_req = 1'b0, sr_exit_req = 1'b0, ref_gnt = 1'b0;
  logic ref_req, ref_urgent, lockout, cke, sr_active;
  logic [2:0] owed;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  sdram_refresh_mgr #(
    .CLK_KHZ(256), .PERIOD_MS(1), .ROWS(16), .T_RC(4), .T_RAS(6),
    .EXIT_NOP(2), .DEFICIT_MAX(6), .URGENT_AT(3)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .sr_enter_req(sr_enter_req),
    .sr_exit_req(sr_exit_req), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .owed(owed), .lockout(lockout), .cke(cke),
    .sr_active(sr_active)
  );

  // {gnt, cycles[8], owed[4], req, lockout, urgent}; edge count after each row in comment
  localparam int NV = 14;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0, 8'd15,  4'd0, 1'b0, 1'b0, 1'b0},  // E15  R1 none yet
    {1'b0, 8'd1,   4'd1, 1'b1, 1'b0, 1'b0},  // E16  R1 R2 first tick
    {1'b0, 8'd32,  4'd3, 1'b1, 1'b0, 1'b1},  // E48  R4 urgent
    {1'b1, 8'd1,   4'd2, 1'b0, 1'b1, 1'b0},  // E49  R2 R5 grant
    {1'b0, 8'd3,   4'd2, 1'b0, 1'b1, 1'b0},  // E52  R5 still locked
    {1'b0, 8'd1,   4'd2, 1'b1, 1'b0, 1'b0},  // E53  R5 window ends
    {1'b1, 8'd1,   4'd1, 1'b0, 1'b1, 1'b0},  // E54  R2 grant
    {1'b1, 8'd4,   4'd1, 1'b1, 1'b0, 1'b0},  // E58  R3 grants while locked ignored
    {1'b0, 8'd6,   4'd2, 1'b1, 1'b0, 1'b0},  // E64  R1 tick
    {1'b1, 8'd1,   4'd1, 1'b0, 1'b1, 1'b0},  // E65  R2
    {1'b0, 8'd4,   4'd1, 1'b1, 1'b0, 1'b0},  // E69  R5
    {1'b1, 8'd1,   4'd0, 1'b0, 1'b1, 1'b0},  // E70  R2 drained
    {1'b0, 8'd10,  4'd1, 1'b1, 1'b0, 1'b0},  // E80  R1
    {1'b0, 8'd128, 4'd6, 1'b1, 1'b0, 1'b1}   // E208 R4 saturated
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    step(3);
    // R11: reset values
    chk("R11 cke", int'(cke), 1);
    chk("R11 outputs", int'({ref_req, lockout, sr_active, ref_urgent, owed}), 0);
    rst_n = 1'b1;
    chk("R11 after release", int'({ref_req, lockout, sr_active, ref_urgent, owed}), 0);

    for (int i = 0; i < NV; i++) begin
      ref_gnt = VEC[i][15];
      step(int'(VEC[i][14:7]));
      n_chk++;
      if ({1'b0, owed, ref_req, lockout, ref_urgent} != VEC[i][6:0]) begin
        n_bad++;
        $display("FAIL R1 R2 R3 R4 R5 vector %0d actual=%b expected=%b",
                 i, {1'b0, owed, ref_req, lockout, ref_urgent}, VEC[i][6:0]);
      end
    end
    ref_gnt = 1'b0;

    // R6: entry at E209
    sr_enter_req = 1'b1;
    step(1);
    sr_enter_req = 1'b0;
    chk("R6 cke low", int'(cke), 0);
    chk("R6 sr_active", int'(sr_active), 1);
    chk("R6 owed cleared", int'(owed), 0);
    chk("R6 no req", int'(ref_req), 0);

    // R7: exit held, honoured at E216 only
    sr_exit_req = 1'b1;
    step(6);
    chk("R7 still low at E215", int'(cke), 0);
    step(1);
    sr_exit_req = 1'b0;
    chk("R7 cke high at E216", int'(cke), 1);
    chk("R7 sr_active off", int'(sr_active), 0);
    chk("R8 lockout at exit", int'(lockout), 1);
    chk("R8 no req at exit", int'(ref_req), 0);
    step(3);
    chk("R8 lockout E219", int'({lockout, ref_req}), 2);
    step(1);
    chk("R9 burst req E220", int'({lockout, ref_req}), 1);
    chk("R9 owed zero", int'(owed), 0);

    // R10: entry during burst ignored
    sr_enter_req = 1'b1;
    step(1);
    sr_enter_req = 1'b0;
    chk("R10 cke stays high", int'(cke), 1);
    chk("R10 sr_active low", int'(sr_active), 0);

    for (int k = 0; k < 16; k++) begin
      ref_gnt = 1'b1;
      step(1);
      ref_gnt = 1'b0;
      step(4);
      if (k == 0) chk("R9 burst grant leaves owed", int'({owed, ref_req}), 1);
      if (k == 1) chk("R9 timer restarted at exit (E231)", int'(owed), 0);
    end
    // E301: five ticks since exit, burst over
    chk("R9 owed after burst", int'(owed), 5);
    chk("R4 urgent after burst", int'(ref_urgent), 1);
    ref_gnt = 1'b1;
    step(1);
    ref_gnt = 1'b0;
    chk("R9 normal grant lowers owed", int'(owed), 4);
    chk("R5 lockout after normal grant", int'(lockout), 1);

    finish_run();
  end
endmodule